// File: doc/BRIEF.md
# Working-Zone Address Bus Encoder

This block sits on the sending side of an off-chip address bus. Its aim is to cut the number of wire transitions that each address transfer causes. It keeps one base register per working zone, and each base register holds the last address used in that zone. When a new address falls within a small signed window around one of the bases, the block sends three things: the zone number, a hit indication, and a word. The word is the previous word with exactly one bit flipped, and the position of that bit encodes the signed distance. When the distance equals the last distance used in that zone, the word is sent again unchanged.

An address that is near no base goes out raw, with the miss flag raised. In that case the least recently used zone is reloaded with the address. The receiving side mirrors the state, so it can rebuild each address from the zone number and the XOR of two consecutive words.

Top module: `wz_addr_encoder`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted address, the word is 0, the zone id is 0 and the miss flag is 0.
- R2: An address hits a zone when (address − base) taken modulo 2^ADDR_W, read as a signed value, lies in −ADDR_W/2 … ADDR_W/2−1. When several zones hit, the lowest-numbered zone is used. A hit drives miss = 0 and the zone id = that zone number.
- R3: On a hit whose distance equals the distance last stored for that zone, the word equals the previous word. The stored distance is 0 after reset.
- R4: On a hit with any other distance v, the word is the previous word XOR (1 << (v + ADDR_W/2)).
- R5: On a miss, miss = 1, the word equals the address, and the zone id keeps its previous value.
- R6: On a miss, the least recently used zone takes the address as its new base. Both hits and misses make the used zone the most recent. After reset, zones are reclaimed in ascending order from zone 0.
- R7: A miss leaves the reloaded zone's stored distance unchanged.
- R8: On a hit, the zone's base becomes the address, so the next distance for that zone is measured from it.
- R9: With the valid strobe low, the outputs hold and no internal state changes, whatever the address input does.
- R10: An address accepted on a clock edge shows up on the outputs after that edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| addr_valid_i | input | 1 | Address strobe |
| addr_i | input | ADDR_W | Address to encode |
| word_o | output | ADDR_W | Word field of the bus |
| ident_o | output | $clog2(NZONE) | Zone number field |
| miss_o | output | 1 | Raw-address flag |

## Verification
The hardest situation to reach from the ports is a hit on a freshly reloaded zone whose distance equals the distance that zone stored before it was evicted. The stimulus gets there in three steps. First it leaves a distance of 7 in zone 1. Then it forces two misses, so that least-recently-used order hands zone 1 back for a new base. Finally it steps exactly 7 from that base and expects the word to repeat. The same sequence also checks the window edges at −8 (hit) and +8 (miss), a hit that wraps below address zero, and a victim order that can only be seen through the zone id of the next hit.

// File: rtl/wz_pkg.sv
package wz_pkg;
  // How the word field is produced for one transfer
  typedef enum logic [1:0] {
    SEND_RAW    = 2'd0,
    SEND_REPEAT = 2'd1,
    SEND_STEP   = 2'd2
  } wz_send_e;
endpackage

// File: rtl/wz_zone_match.sv
module wz_zone_match #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int UP_W = ADDR_W - OFF_W + 1;

  logic [ADDR_W-1:0] diff;
  logic [UP_W-1:0]   upper;

  assign diff  = addr_i - base_i;
  // the distance fits when every bit above the signed field copies its sign
  assign upper = diff[ADDR_W-1:OFF_W-1];
  assign hit_o = (upper == '0) || (upper == '1);
  assign off_o = diff[OFF_W-1:0];
endmodule

// File: rtl/wz_lru.sv
module wz_lru #(
  parameter int NZONE = 4,
  localparam int ZID_W = $clog2(NZONE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_en_i,
  input  logic [ZID_W-1:0] use_id_i,
  output logic [ZID_W-1:0] victim_o
);
  // slot 0 holds the least recent zone, slot NZONE-1 the most recent
  logic [ZID_W-1:0] ord_q [NZONE];
  logic [ZID_W-1:0] ord_d [NZONE];
  logic [ZID_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < NZONE; i++) begin
      if (ord_q[i] == use_id_i) pos = ZID_W'(i);
    end
    for (int i = 0; i < NZONE; i++) begin
      if (i == NZONE - 1)       ord_d[i] = use_id_i;
      else if (ZID_W'(i) < pos) ord_d[i] = ord_q[i];
      else                      ord_d[i] = ord_q[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NZONE; i++) ord_q[i] <= ZID_W'(i);
    end else if (use_en_i) begin
      for (int i = 0; i < NZONE; i++) ord_q[i] <= ord_d[i];
    end
  end

  assign victim_o = ord_q[0];
endmodule

// File: rtl/wz_addr_encoder.sv
module wz_addr_encoder
  import wz_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NZONE  = 4,
  localparam int ZID_W = $clog2(NZONE),
  localparam int OFF_W = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] word_o,
  output logic [ZID_W-1:0]  ident_o,
  output logic              miss_o
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic [ADDR_W-1:0] pref_q [NZONE];
  logic [ADDR_W-1:0] pref_d [NZONE];
  logic [OFF_W-1:0]  poff_q [NZONE];
  logic [OFF_W-1:0]  poff_d [NZONE];
  logic [ADDR_W-1:0] word_q, word_d;
  logic [ZID_W-1:0]  ident_q, ident_d;
  logic              miss_q, miss_d;

  // per-zone distance match
  logic              hit_z [NZONE];
  logic [OFF_W-1:0]  off_z [NZONE];

  for (genvar g = 0; g < NZONE; g++) begin : g_zone
    wz_zone_match #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
    ) i_match (
      .addr_i (addr_i),
      .base_i (pref_q[g]),
      .hit_o  (hit_z[g]),
      .off_o  (off_z[g])
    );
  end

  // lowest-numbered hitting zone wins
  logic             any_hit;
  logic [ZID_W-1:0] hit_id;
  logic [OFF_W-1:0] hit_off;

  always_comb begin
    any_hit = 1'b0;
    hit_id  = '0;
    for (int i = NZONE - 1; i >= 0; i--) begin
      if (hit_z[i]) begin
        any_hit = 1'b1;
        hit_id  = ZID_W'(i);
      end
    end
    hit_off = off_z[hit_id];
  end

  // replacement order
  logic [ZID_W-1:0] victim;
  logic [ZID_W-1:0] use_id;

  assign use_id = any_hit ? hit_id : victim;

  wz_lru #(
    .NZONE (NZONE)
  ) i_lru (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .use_en_i (addr_valid_i),
    .use_id_i (use_id),
    .victim_o (victim)
  );

  // one-hot step: flipping the sign bit of the distance gives v + ADDR_W/2
  logic [OFF_W-1:0]  step_pos;
  logic [ADDR_W-1:0] step_code;
  wz_send_e          kind;

  assign step_pos  = {~hit_off[OFF_W-1], hit_off[OFF_W-2:0]};
  assign step_code = ADDR_W'(1) << step_pos;

  always_comb begin
    if (!any_hit)                         kind = SEND_RAW;
    else if (hit_off == poff_q[hit_id])   kind = SEND_REPEAT;
    else                                  kind = SEND_STEP;
  end

  // next state
  always_comb begin
    for (int i = 0; i < NZONE; i++) begin
      pref_d[i] = pref_q[i];
      poff_d[i] = poff_q[i];
    end
    ident_d = ident_q;
    miss_d  = miss_q;
    word_d  = word_q;
    if (addr_valid_i) begin
      case (kind)
        SEND_RAW:    word_d = addr_i;
        SEND_STEP:   word_d = word_q ^ step_code;
        default:     word_d = word_q;
      endcase
      if (any_hit) begin
        miss_d         = 1'b0;
        ident_d        = hit_id;
        pref_d[hit_id] = addr_i;
        poff_d[hit_id] = hit_off;
      end else begin
        miss_d         = 1'b1;
        pref_d[victim] = addr_i;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < NZONE; i++) begin
        pref_q[i] <= '0;
        poff_q[i] <= '0;
      end
      word_q  <= '0;
      ident_q <= '0;
      miss_q  <= 1'b0;
    end else if (addr_valid_i) begin
      for (int i = 0; i < NZONE; i++) begin
        pref_q[i] <= pref_d[i];
        poff_q[i] <= poff_d[i];
      end
      word_q  <= word_d;
      ident_q <= ident_d;
      miss_q  <= miss_d;
    end
  end

  assign word_o  = word_q;
  assign ident_o = ident_q;
  assign miss_o  = miss_q;
endmodule

// File: rtl/wz_addr_encoder_chk.sv
module wz_addr_encoder_chk #(
  parameter int ADDR_W = 16,
  parameter int NZONE  = 4,
  localparam int ZID_W = $clog2(NZONE)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] word_o,
  input logic [ZID_W-1:0]  ident_o,
  input logic              miss_o
);
  AST_MISS_SENDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_i ##1 miss_o) |-> (word_o == $past(addr_i))); // R5

  AST_MISS_IDENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_i ##1 miss_o) |-> (ident_o == $past(ident_o))); // R5

  AST_HIT_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_i ##1 !miss_o) |-> ($countones(word_o ^ $past(word_o)) <= 1)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid_i |=> ($stable(word_o) && $stable(ident_o) && $stable(miss_o))); // R9
endmodule

bind wz_addr_encoder wz_addr_encoder_chk #(
  .ADDR_W (ADDR_W),
  .NZONE  (NZONE)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_valid_i (addr_valid_i),
  .addr_i       (addr_i),
  .word_o       (word_o),
  .ident_o      (ident_o),
  .miss_o       (miss_o)
);

// File: tb/test_wz_addr_encoder.sv
module test_wz_addr_encoder;
  localparam int AW = 16;
  localparam int NZ = 4;
  localparam int IW = 2;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          valid;
  logic [AW-1:0] addr;
  logic [AW-1:0] word;
  logic [IW-1:0] ident;
  logic          miss;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  wz_addr_encoder #(.ADDR_W(AW), .NZONE(NZ)) i_wz_addr_encoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid_i (valid),
    .addr_i       (addr),
    .word_o       (word),
    .ident_o      (ident),
    .miss_o       (miss)
  );

  // {address, expected word, expected zone id, expected miss}
  localparam logic [AW+AW+IW:0] VEC [NV] = '{
    {16'h0003, 16'h0800, 2'd0, 1'b0},  // R2 R4 all zones hit, zone 0 wins, +3 -> bit 11
    {16'h0006, 16'h0800, 2'd0, 1'b0},  // R3 R8 same +3 again
    {16'h1000, 16'h1000, 2'd0, 1'b1},  // R5 R6 miss, zone 1 reclaimed
    {16'h0FFC, 16'h1010, 2'd1, 1'b0},  // R4 -4 -> bit 4
    {16'h0FF8, 16'h1010, 2'd1, 1'b0},  // R3
    {16'h0FFF, 16'h9010, 2'd1, 1'b0},  // R4 +7 -> bit 15
    {16'h0000, 16'h9014, 2'd0, 1'b0},  // R2 R4 -6 -> bit 2
    {16'h0001, 16'h9214, 2'd0, 1'b0},  // R4 +1 -> bit 9
    {16'h5000, 16'h5000, 2'd0, 1'b1},  // R5 R6 zone 2 reclaimed
    {16'h5000, 16'h5000, 2'd2, 1'b0},  // R3 R6 distance 0 equals reset value
    {16'h0A000 > 0 ? 16'hA000 : 16'h0, 16'hA000, 2'd2, 1'b1},  // R5 zone 3 reclaimed
    {16'h2000, 16'h2000, 2'd2, 1'b1},  // R6 zone 1 reclaimed
    {16'h2007, 16'h2000, 2'd1, 1'b0},  // R7 +7 kept across eviction
    {16'h1FFF, 16'h2001, 2'd1, 1'b0},  // R2 R4 -8 edge -> bit 0
    {16'h2007, 16'h2007, 2'd1, 1'b1}   // R2 R5 +8 is outside the window
  };

  task automatic check(input string req, input logic [AW+IW:0] got,
                       input logic [AW+IW:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got word=%h id=%0d miss=%0b exp word=%h id=%0d miss=%0b",
               req, got[AW+IW:IW+1], got[IW:1], got[0],
               exp[AW+IW:IW+1], exp[IW:1], exp[0]);
    end
  endtask

  // accept one address on the next rising edge, leave strobe low after it
  task automatic xfer(input logic [AW-1:0] a);
    addr  = a;
    valid = 1'b1;
    @(posedge clk);
    #5;
    valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R1", {word, ident, miss}, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    check("R1", {word, ident, miss}, '0);
  endtask

  initial begin
    rst_n = 1'b0;
    valid = 1'b0;
    addr  = '0;
    #5;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][AW+AW+IW:AW+IW+1]);
      check($sformatf("R10 row%0d", i), {word, ident, miss}, VEC[i][AW+IW:0]);
    end

    // R9: address wiggles with strobe low
    for (int i = 0; i < 3; i++) begin
      addr = 16'h2100 + AW'(i);
      @(posedge clk);
      #5;
      check("R9", {word, ident, miss}, {16'h2007, 2'd1, 1'b0} | 19'd1);
    end
    // base of zone 0 still 0x2007 and its stored distance still +1 (R7 R9)
    xfer(16'h2008);
    check("R9 R7", {word, ident, miss}, {16'h2007, 2'd0, 1'b0});

    // R10: nothing moves before the accepting edge
    addr  = 16'h2009;
    valid = 1'b1;
    #3;
    check("R10", {word, ident, miss}, {16'h2007, 2'd0, 1'b0});
    @(posedge clk);
    #5;
    valid = 1'b0;
    check("R10", {word, ident, miss}, {16'h2007, 2'd0, 1'b0});

    // R1 again in mid-run, then wrap and priority cases
    do_reset();
    xfer(16'hFFFC);
    check("R2 wrap", {word, ident, miss}, {16'h0010, 2'd0, 1'b0});
    xfer(16'hFFF4);
    check("R4 R8", {word, ident, miss}, {16'h0011, 2'd0, 1'b0});
    xfer(16'h0004);
    check("R2 lowest", {word, ident, miss}, {16'h1011, 2'd1, 1'b0});
    xfer(16'h8000);
    check("R5", {word, ident, miss}, {16'h8000, 2'd1, 1'b1});
    xfer(16'h8002);
    check("R6 victim", {word, ident, miss}, {16'h8400, 2'd2, 1'b0});

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule